// File: doc/BRIEF.md
# Dual Down-Counting Timer Unit

A register-mapped peripheral holding two independent 32-bit countdown timers. It sits on a simple bus where every access completes in one cycle. Software programs each timer's start count and reload value. It then selects in a shared control word whether the timer runs, whether it reloads itself, and what it counts. A timer can count a prescaled version of the fabric clock or an external fixed-rate tick strobe.

When a timer expires it raises a sticky event flag. An interrupt line stays high while any flag is set. Software clears flags by writing zeros to the chosen positions of the status word. A one-shot delay is programmed in three steps: clear the flag, write the delay into the live count, then enable the timer with reload off. A periodic tick of P counts uses a reload value of P-1. A free-running time base loads all ones into both the reload and the live count, and lets the counter wrap.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Control word (offset 0x00) layout: enables at bits 0 and 2, auto-reload enables at bits 1 and 3, source selects at bits 11 and 12, 3-bit prescaler fields at bits 21:19 and 24:22, for timers 0 and 1 in that order. Writing all ones reads back 0x01F8180F. Unmapped offsets such as 0x08 read zero.
- R3: A write to a value register (timer 0 at 0x14, timer 1 at 0x1C) replaces the live count at that clock edge. It takes priority over a tick in the same cycle, and the value read back is the live count.
- R4: An enabled timer decrements by one per tick. The tick that takes it from 1 to 0 sets its event flag. With auto-reload off it then stays at zero.
- R5: With auto-reload on, a tick at count zero loads the reload value (timer 0 at 0x10, timer 1 at 0x18) without setting an event. A reload of P-1 therefore gives one event every P ticks, and a reload of all ones wraps 0 to 0xFFFFFFFF.
- R6: With the source select clear, a prescaler field value N gives one tick every 2^N clock cycles. The first tick comes 2^N cycles after the enable takes effect, so N=5 gives a 32-cycle period.
- R7: While a timer is disabled its count holds and its prescaler restarts. After re-enabling, the first tick again comes a full 2^N cycles later.
- R8: With the source select set, the timer ticks only in cycles where `tick_i` is high, whatever the prescaler field holds.
- R9: Status word (offset 0x04): timer 0 event at bit 0, timer 1 event at bit 8. The flags are sticky. A status write clears each flag written as 0 and keeps each flag written as 1.
- R10: An event and a clearing status write in the same cycle leave the flag set.
- R11: `irq_o` is high exactly when at least one event flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access select |
| wr_i | input | 1 | Write strobe, qualified by sel_i |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the access |
| tick_i | input | 1 | Fixed-rate tick strobe, one cycle per tick |
| irq_o | output | 1 | Interrupt, high while any event flag is set |

## Verification
The countdown is tried in several set-ups. A one-shot run on the undivided clock shows whether each tick lands on the expected cycle and whether the counter parks at zero. A periodic run with a divide-by-2 prescaler on timer 1 separates a correct reload point from an off-by-one period, and it also places a status clear on the very cycle of an event. Strobe-driven counting with deliberately idle gaps shows that only `tick_i` advances a timer whose source select is set. A divide-by-32 run that is stopped and restarted tells a restarted prescaler apart from one that keeps its phase. An all-ones free-running run, with a value write part way through, covers both the wrap and the priority of a value write over a tick.

// File: rtl/twin_tmr_pkg.sv
package twin_tmr_pkg;
  localparam int NCH   = 2;
  localparam int DIV_W = 3;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;

  typedef struct packed {
    logic             en;
    logic             rl;
    logic             src;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  function automatic int en_bit(int ch);   return 2 * ch;      endfunction
  function automatic int rl_bit(int ch);   return 2 * ch + 1;  endfunction
  function automatic int src_bit(int ch);  return 11 + ch;     endfunction
  function automatic int div_lsb(int ch);  return 19 + 3 * ch; endfunction
  function automatic int evt_bit(int ch);  return 8 * ch;      endfunction
  function automatic int rld_off(int ch);  return 'h10 + 8 * ch; endfunction
  function automatic int val_off(int ch);  return 'h14 + 8 * ch; endfunction
endpackage

// File: rtl/twin_tmr_prescale.sv
module twin_tmr_prescale #(
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  localparam int MAXW = (1 << PW) - 1;

  logic [MAXW-1:0] pcnt_q;
  logic [MAXW-1:0] mask;

  assign mask   = (MAXW'(1) << div_i) - MAXW'(1);
  assign tick_o = run_i && ((pcnt_q & mask) == mask);

  // restart phase whenever the timer is stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + MAXW'(1);
  end
endmodule

// File: rtl/twin_tmr_counter.sv
module twin_tmr_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  input  logic          reload_en_i,
  input  logic [CW-1:0] reload_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && !load_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        if (reload_en_i) cnt_q <= reload_val_i;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  output logic          irq_o
);
  import twin_tmr_pkg::*;

  localparam int PW = DIV_W;

  chan_cfg_t     cfg_q  [NCH];
  logic [CW-1:0] rld_q  [NCH];
  logic [CW-1:0] cnt    [NCH];
  logic          evt_q  [NCH];
  logic          expire [NCH];

  logic          bus_we, ctrl_we, stat_we;
  logic [DW-1:0] ctrl_rd, stat_rd;

  assign bus_we  = sel_i && wr_i;
  assign ctrl_we = bus_we && (addr_i == AW'(OFF_CTRL));
  assign stat_we = bus_we && (addr_i == AW'(OFF_STAT));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int EB = en_bit(ch);
    localparam int RB = rl_bit(ch);
    localparam int SB = src_bit(ch);
    localparam int DB = div_lsb(ch);
    localparam int VB = evt_bit(ch);

    logic rld_we, val_we, ptick, tick_sel;

    assign rld_we = bus_we && (addr_i == AW'(rld_off(ch)));
    assign val_we = bus_we && (addr_i == AW'(val_off(ch)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[ch] <= '0;
      end else if (ctrl_we) begin
        cfg_q[ch].en  <= wdata_i[EB];
        cfg_q[ch].rl  <= wdata_i[RB];
        cfg_q[ch].src <= wdata_i[SB];
        cfg_q[ch].div <= wdata_i[DB +: PW];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rld_q[ch] <= '0;
      else if (rld_we) rld_q[ch] <= wdata_i[CW-1:0];
    end

    twin_tmr_prescale #(.PW(PW)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (cfg_q[ch].en),
      .div_i  (cfg_q[ch].div),
      .tick_o (ptick)
    );

    assign tick_sel = cfg_q[ch].en && (cfg_q[ch].src ? tick_i : ptick);

    twin_tmr_counter #(.CW(CW)) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (val_we),
      .load_val_i   (wdata_i[CW-1:0]),
      .tick_i       (tick_sel),
      .reload_en_i  (cfg_q[ch].rl),
      .reload_val_i (rld_q[ch]),
      .cnt_o        (cnt[ch]),
      .expire_o     (expire[ch])
    );

    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       evt_q[ch] <= 1'b0;
      else if (expire[ch])               evt_q[ch] <= 1'b1;
      else if (stat_we && !wdata_i[VB])  evt_q[ch] <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    stat_rd = '0;
    irq_o   = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      ctrl_rd[en_bit(ch)]        = cfg_q[ch].en;
      ctrl_rd[rl_bit(ch)]        = cfg_q[ch].rl;
      ctrl_rd[src_bit(ch)]       = cfg_q[ch].src;
      ctrl_rd[div_lsb(ch) +: PW] = cfg_q[ch].div;
      stat_rd[evt_bit(ch)]       = evt_q[ch];
      irq_o                      = irq_o | evt_q[ch];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      if (addr_i == AW'(OFF_CTRL)) rdata_o = ctrl_rd;
      if (addr_i == AW'(OFF_STAT)) rdata_o = stat_rd;
      for (int ch = 0; ch < NCH; ch++) begin
        if (addr_i == AW'(rld_off(ch))) rdata_o = DW'(rld_q[ch]);
        if (addr_i == AW'(val_off(ch))) rdata_o = DW'(cnt[ch]);
      end
    end
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          en0_i,
  input logic          rl0_i,
  input logic [CW-1:0] cnt0_i,
  input logic          evt0_i,
  input logic          evt1_i,
  input logic          irq_i
);
  logic wr_val0, wr_stat;
  assign wr_val0 = sel_i && wr_i && (addr_i == AW'(twin_tmr_pkg::val_off(0)));
  assign wr_stat = sel_i && wr_i && (addr_i == AW'(twin_tmr_pkg::OFF_STAT));

  AST_VALUE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_val0 |=> cnt0_i == $past(wdata_i[CW-1:0])); // R3

  AST_ONESHOT_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && !rl0_i && cnt0_i == '0 && !wr_val0) |=> cnt0_i == '0); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en0_i && !wr_val0) |=> $stable(cnt0_i)); // R7

  AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt0_i && !(wr_stat && !wdata_i[0])) |=> evt0_i); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> (!evt0_i && !evt1_i)); // R11
endmodule

bind twin_timer twin_timer_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en0_i   (cfg_q[0].en),
  .rl0_i   (cfg_q[0].rl),
  .cnt0_i  (cnt[0]),
  .evt0_i  (evt_q[0]),
  .evt1_i  (evt_q[1]),
  .irq_i   (irq_o)
);

// File: tb/sim_twin_timer.sv
module sim_twin_timer;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_RL0 = 6'h10,
                         A_VAL0 = 6'h14, A_RL1 = 6'h18, A_VAL1 = 6'h1C,
                         A_HOLE = 6'h08;

  typedef struct {
    int          kind;   // 0 read data, 1 irq level
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twin_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d; tick = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    sel = 1; wr = 0; addr = a; tick = 0;
    it.kind = 0; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    it.kind = 1; it.exp = {31'd0, e}; it.req = r;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = 0; wr = 0; tick = 0;
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    sel = 0; wr = 0; tick = 1;
  endtask

  // monitor: compare a quarter period before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = (it.kind == 0) ? rdata : {31'd0, irq};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(A_CTRL, 0, "R1"); chk_irq(0, "R1");
    bus_rd(A_STAT, 0, "R1");
    bus_rd(A_RL0, 0, "R1");
    bus_rd(A_VAL0, 0, "R1");
    bus_rd(A_RL1, 0, "R1");
    bus_rd(A_VAL1, 0, "R1");

    // R2 layout
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, 32'h01F8_180F, "R2");
    bus_wr(A_CTRL, 0);
    bus_rd(A_HOLE, 0, "R2");

    // R4 one-shot on undivided clock
    bus_wr(A_VAL0, 5);
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_VAL0, 5, "R4");
    bus_rd(A_VAL0, 4, "R4");
    bus_rd(A_VAL0, 3, "R4");
    bus_rd(A_VAL0, 2, "R4");
    bus_rd(A_VAL0, 1, "R4");
    bus_rd(A_VAL0, 0, "R4");
    bus_rd(A_STAT, 32'h1, "R4"); chk_irq(1, "R11");
    bus_rd(A_VAL0, 0, "R4");

    // R9 write-one keeps, write-zero clears
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, 32'h1, "R9");
    bus_wr(A_STAT, 32'hFFFF_FFFE);
    bus_rd(A_STAT, 0, "R9"); chk_irq(0, "R11");
    bus_wr(A_CTRL, 0);

    // R5/R6/R10 periodic timer 1, reload 2, divide by 2
    bus_wr(A_RL1, 2);
    bus_wr(A_VAL1, 2);
    bus_wr(A_CTRL, 32'h0040_000C);
    bus_rd(A_VAL1, 2, "R6");
    bus_rd(A_VAL1, 2, "R6");
    bus_rd(A_VAL1, 1, "R6");
    bus_rd(A_VAL1, 1, "R6");
    bus_rd(A_VAL1, 0, "R6");
    bus_rd(A_STAT, 32'h100, "R9"); chk_irq(1, "R11");
    bus_wr(A_STAT, 32'hFFFF_FEFF);
    bus_rd(A_STAT, 0, "R9");
    bus_rd(A_VAL1, 1, "R5");
    bus_wr(A_STAT, 32'hFFFF_FEFF);        // lands on the next event edge
    bus_rd(A_STAT, 32'h100, "R10");
    bus_wr(A_CTRL, 0);
    bus_wr(A_STAT, 0);
    bus_rd(A_STAT, 0, "R9");

    // R8 external strobe source
    bus_wr(A_VAL0, 3);
    bus_wr(A_CTRL, 32'h801);
    bus_rd(A_VAL0, 3, "R8");
    bus_rd(A_VAL0, 3, "R8");
    strobe();
    bus_rd(A_VAL0, 2, "R8");
    idle(1);
    bus_rd(A_VAL0, 2, "R8");
    strobe();
    strobe();
    bus_rd(A_VAL0, 0, "R8");
    bus_rd(A_STAT, 32'h1, "R8");
    bus_wr(A_CTRL, 0);
    bus_wr(A_STAT, 0);

    // R5 free-running wrap, R3 value overwrite
    bus_wr(A_RL0, 32'hFFFF_FFFF);
    bus_wr(A_VAL0, 1);
    bus_wr(A_CTRL, 32'h3);
    bus_rd(A_VAL0, 1, "R5");
    bus_rd(A_VAL0, 0, "R5");
    bus_rd(A_VAL0, 32'hFFFF_FFFF, "R5");
    bus_rd(A_VAL0, 32'hFFFF_FFFE, "R5");
    bus_wr(A_VAL0, 32'h100);
    bus_rd(A_VAL0, 32'h100, "R3");
    bus_rd(A_VAL0, 32'hFF, "R3");
    bus_wr(A_CTRL, 0);
    bus_wr(A_STAT, 0);

    // R6/R7 divide by 32, stop and restart
    bus_wr(A_VAL0, 2);
    bus_wr(A_CTRL, 32'h0028_0001);
    idle(31);
    bus_rd(A_VAL0, 2, "R6");
    bus_rd(A_VAL0, 1, "R6");
    bus_wr(A_CTRL, 0);
    bus_wr(A_CTRL, 32'h0028_0001);
    idle(31);
    bus_rd(A_VAL0, 1, "R7");
    bus_rd(A_VAL0, 0, "R7");
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule